// File: doc/BRIEF.md
# Bit-Staggered Lane Interleaver with Lane Marking

This block sits between a serial data source and a bank of external block encoders on one side, and between those encoders and the channel mapper on the other. It spreads the incoming bit stream across the lanes one bit at a time: bit 0 goes to lane 0, bit 1 to lane 1, and so on, wrapping after the last lane. On the return path it collects one code symbol from each lane in turn. Neighbouring symbols on the channel therefore come from different codewords, so a channel error burst is shared among all the lane codewords. The lane count is set by a parameter from 2 to 8. The same number of encoders serves every channel path.

An optional marking feature inverts every bit sent to one chosen lane. With this, a receiver can find which of its decoders holds lane 0. The enable and the lane index are configuration inputs. The block captures them only when it is idle, so a change in mid-stream cannot shift the mark partway through a codeword. The collection rotation steps only in a cycle where every lane offers a symbol, which keeps all lanes in step with each other.

Top module: `stagger_lane_mux`

## Requirements
- R1: Reset clears `lane_tx_valid`, `ch_valid` and the captured marking enable. The first input bit after reset goes to lane 0, and the first symbol collected is taken from lane 0.
- R2: The block sends input bit number i (counted from 0 since reset) to lane i mod N_LANES. One cycle after `in_valid` is accepted, exactly that lane's `lane_tx_valid` bit is high. Bit k of `lane_tx_valid`/`lane_tx_bit` belongs to lane k.
- R3: A cycle with `in_valid` low raises no `lane_tx_valid` bit in the next cycle, and it does not advance the lane the next bit goes to.
- R4: Symbol number j handed to the channel (counted from 0) comes from lane j mod N_LANES. It appears on `ch_sym` with `ch_valid` high one cycle after the take. Lane k's symbol sits at bits [k*SYM_W +: SYM_W] of `lane_rx_sym`.
- R5: A take happens only in a cycle where every `lane_rx_valid` bit is high. In any other cycle, all `lane_rx_ready` bits are low, `ch_valid` is low in the next cycle, and the collection lane does not advance. In a take cycle, only the current lane's `lane_rx_ready` bit is high.
- R6: When marking is captured as enabled, every bit sent to the captured lane index is inverted and all other lanes carry the input unchanged. A captured index of N_LANES or above marks no lane.
- R7: The block captures `cover_en` and `cover_lane` only in a cycle where `in_valid` is low and both the dealing and the collection lane are 0. Changes in any other cycle have no effect.
- R8: Both lane indices wrap from N_LANES-1 back to 0. This includes lane counts that are not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Serial input data bit |
| cover_en | input | 1 | Lane marking enable (captured when idle) |
| cover_lane | input | IW | Index of the lane to invert (captured when idle) |
| lane_tx_valid | output | N_LANES | One-hot strobe: a bit for that lane's encoder |
| lane_tx_bit | output | N_LANES | Bit for each lane's encoder |
| lane_rx_valid | input | N_LANES | Each encoder has a code symbol ready |
| lane_rx_sym | input | N_LANES*SYM_W | Code symbols from the encoders, lane k at slice k |
| lane_rx_ready | output | N_LANES | One-hot pop of the lane whose symbol is taken |
| ch_valid | output | 1 | Channel symbol present |
| ch_sym | output | SYM_W | Channel symbol |

## Verification
The assertions assume that the encoders hold `lane_rx_valid` and `lane_rx_sym` steady until they are popped, and that the configuration inputs only need to take effect at an idle point. The stimulus drives only the lanes that the bench's own encoder models present. It changes configuration either in a deliberate idle cycle or, to check that such changes are ignored, while the dealing lane is non-zero. Lane count 3 is used so that the index wrap is exercised at a value that is not a power of two.

// File: rtl/stagger_lane_mux.sv
module stagger_lane_mux #(
  parameter int N_LANES = 4,
  parameter int SYM_W   = 4,
  localparam int IW     = $clog2(N_LANES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_bit,
  input  logic                       cover_en,
  input  logic [IW-1:0]              cover_lane,
  output logic [N_LANES-1:0]         lane_tx_valid,
  output logic [N_LANES-1:0]         lane_tx_bit,
  input  logic [N_LANES-1:0]         lane_rx_valid,
  input  logic [N_LANES*SYM_W-1:0]   lane_rx_sym,
  output logic [N_LANES-1:0]         lane_rx_ready,
  output logic                       ch_valid,
  output logic [SYM_W-1:0]           ch_sym
);

  localparam logic [IW-1:0] LAST = IW'(N_LANES - 1);

  logic [IW-1:0]    in_idx, out_idx, cov_lane_q;
  logic             cov_en_q;
  logic             idle, take;
  logic [SYM_W-1:0] sym_arr [N_LANES];

  assign idle = !in_valid && in_idx == '0 && out_idx == '0;
  assign take = &lane_rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cov_en_q   <= 1'b0;
      cov_lane_q <= '0;
    end else if (idle) begin
      cov_en_q   <= cover_en;
      cov_lane_q <= cover_lane;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_idx        <= '0;
      lane_tx_valid <= '0;
    end else begin
      lane_tx_valid <= '0;
      if (in_valid) begin
        lane_tx_valid[in_idx] <= 1'b1;
        in_idx <= (in_idx == LAST) ? '0 : in_idx + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_tx_bit[k] <= 1'b0;
      else if (in_valid)
        lane_tx_bit[k] <= in_bit ^ (cov_en_q && cov_lane_q == IW'(k));
    end
    assign sym_arr[k]       = lane_rx_sym[k*SYM_W +: SYM_W];
    assign lane_rx_ready[k] = take && out_idx == IW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_idx  <= '0;
      ch_valid <= 1'b0;
      ch_sym   <= '0;
    end else begin
      ch_valid <= take;
      if (take) begin
        ch_sym  <= sym_arr[out_idx];
        out_idx <= (out_idx == LAST) ? '0 : out_idx + 1'b1;
      end
    end
  end

  // R2
  tx_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_tx_valid));

  // R3
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> lane_tx_valid == '0);

  // R5
  rx_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_rx_ready != '0) |-> (&lane_rx_valid && $onehot(lane_rx_ready)));

  // R5
  ch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(&lane_rx_valid) |=> !ch_valid);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(cov_en_q) && $stable(cov_lane_q)));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(in_idx) < N_LANES) && (int'(out_idx) < N_LANES));

endmodule

// File: tb/stagger_lane_mux_test.sv
module stagger_lane_mux_test;
  localparam int NL = 3;
  localparam int SW = 4;
  localparam int IW = $clog2(NL);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, cover_en = 1'b0;
  logic [IW-1:0] cover_lane = '0;
  logic [NL-1:0] lane_tx_valid, lane_tx_bit, lane_rx_ready;
  logic [NL-1:0] lane_ok = '0;
  logic [NL*SW-1:0] lane_rx_sym;
  logic ch_valid;
  logic [SW-1:0] ch_sym;
  logic [1:0] cnt [NL];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  stagger_lane_mux #(.N_LANES(NL), .SYM_W(SW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .cover_en(cover_en), .cover_lane(cover_lane),
    .lane_tx_valid(lane_tx_valid), .lane_tx_bit(lane_tx_bit),
    .lane_rx_valid(lane_ok), .lane_rx_sym(lane_rx_sym),
    .lane_rx_ready(lane_rx_ready), .ch_valid(ch_valid), .ch_sym(ch_sym));

  always_comb
    for (int k = 0; k < NL; k++) lane_rx_sym[k*SW +: SW] = {2'(k), cnt[k]};

  always @(posedge clk)
    for (int k = 0; k < NL; k++)
      if (rst) cnt[k] <= '0;
      else if (lane_rx_ready[k]) cnt[k] <= cnt[k] + 2'd1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; lane_ok = '0;
    cover_en = 1'b0; cover_lane = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); in_valid = 1'b1; in_bit = b;
    @(posedge clk); #1;
  endtask

  task automatic stop_input();
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(lane_tx_valid == '0, "R1 tx_valid", lane_tx_valid, 0);
    check(ch_valid == 1'b0, "R1 ch_valid", ch_valid, 0);
    lane_ok = '1; #1;
    check(lane_rx_ready == 3'b001, "R1 first pop lane0", lane_rx_ready, 1);
    lane_ok = '0;
    send_bit(1'b1);
    check(lane_tx_valid == 3'b001, "R1 first bit lane0", lane_tx_valid, 1);
    check(lane_tx_bit[0] == 1'b1, "R1 first bit value", lane_tx_bit[0], 1);
    stop_input();
  endtask

  task automatic t_deal();
    logic [6:0] pat = 7'b1011001;
    do_reset();
    for (int i = 0; i < 7; i++) begin
      send_bit(pat[i]);
      check(lane_tx_valid == NL'(1 << (i % NL)), "R2 R8 lane strobe", lane_tx_valid, 1 << (i % NL));
      check(lane_tx_bit[i % NL] == pat[i], "R2 lane bit", lane_tx_bit[i % NL], pat[i]);
    end
    stop_input();
  endtask

  task automatic t_gap();
    do_reset();
    send_bit(1'b0);
    stop_input();
    repeat (2) begin
      @(posedge clk); #1;
      check(lane_tx_valid == '0, "R3 no strobe on gap", lane_tx_valid, 0);
    end
    send_bit(1'b1);
    check(lane_tx_valid == 3'b010, "R3 gap keeps lane", lane_tx_valid, 2);
    stop_input();
  endtask

  task automatic t_collect();
    do_reset();
    lane_ok = '1;
    for (int j = 0; j < 7; j++) begin
      @(posedge clk); #1;
      check(ch_valid, "R4 ch_valid", ch_valid, 1);
      check(ch_sym == {2'(j % NL), 2'(j / NL)}, "R4 R8 rotation", ch_sym, {2'(j % NL), 2'(j / NL)});
    end
    @(negedge clk) lane_ok = '0;
  endtask

  task automatic t_stall();
    do_reset();
    lane_ok = 3'b101;
    repeat (3) begin
      @(posedge clk); #1;
      check(!ch_valid, "R5 no take on stall", ch_valid, 0);
      check(lane_rx_ready == '0, "R5 no pop on stall", lane_rx_ready, 0);
    end
    @(negedge clk) lane_ok = '1;
    @(posedge clk); #1;
    check(ch_valid && ch_sym == 4'h0, "R5 resume lane0", ch_sym, 0);
    @(posedge clk); #1;
    check(ch_valid && ch_sym == 4'h4, "R5 resume lane1", ch_sym, 4);
    @(negedge clk) lane_ok = '0;
  endtask

  task automatic t_cover();
    do_reset();
    cover_en = 1'b1; cover_lane = 2'd1;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      send_bit(1'b0);
      check(lane_tx_bit[i % NL] == (i % NL == 1), "R6 R7 marked lane", lane_tx_bit[i % NL], i % NL == 1);
    end
    stop_input();
    do_reset();
    cover_en = 1'b1; cover_lane = 2'd3;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      send_bit(1'b0);
      check(lane_tx_bit[i] == 1'b0, "R6 out of range index", lane_tx_bit[i], 0);
    end
    stop_input();
  endtask

  task automatic t_cfg_hold();
    do_reset();
    @(posedge clk);
    send_bit(1'b0);
    cover_en = 1'b1; cover_lane = 2'd0;
    for (int i = 1; i < 6; i++) begin
      send_bit(1'b0);
      check(lane_tx_bit[i % NL] == 1'b0, "R7 change ignored", lane_tx_bit[i % NL], 0);
    end
    stop_input();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_deal();
    t_gap();
    t_collect();
    t_stall();
    t_cover();
    t_cfg_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule